// File: doc/BRIEF.md
# BCD Calendar Clock with Access Freeze

This block keeps wall-clock time and a calendar: seconds, minutes, hours, day of month, weekday, month and a two-digit year, all stored in packed BCD. A prescaler counts cycles in which `oscEn` is high. Each time it has seen `DIV` of them it issues a one-second tick, and the tick advances the counter chain. A carry ripples from seconds up to years, and the chain handles month lengths and leap years. Hours are kept in 24-hour form or in 12-hour form with an AM/PM bit, chosen by `hour12`.

A host reaches the counters through a small register port. While the host holds `accActive`, the counters do not move, so a multi-register read or write always sees one consistent time. One tick that arrives during such a window is remembered and applied in the first cycle after the window closes. Any further ticks in the same window are lost. A register write restarts the prescaler and drops a remembered tick, so counting resumes from the value just written. `stopHold` keeps the prescaler cleared, so time starts exactly `DIV` enabled cycles after it is released. An oscillator-stop flag is set at reset and by `oscStopEvt`. The host can read it and overwrite it.

Top module: `rtc_calendar_top`

## Requirements
- R1: Register map (address: content): 0 = {oscillator-stop flag in bit 7, seconds 00-59 BCD in bits 6:0}, 1 = minutes 00-59 BCD, 2 = hours, 3 = day 01-31 BCD, 4 = weekday 0-6 binary, 5 = month 01-12 BCD, 6 = year 00-99 BCD. Unused high bits read 0. After reset the registers read 0x80, 0x00, 0x00, 0x01, 0x00, 0x01, 0x00.
- R2: Each tick adds one second. Seconds 59 wraps to 00 and carries into minutes. Minutes 59 wraps to 00 and carries into hours. In 24-hour mode, hours 23 wraps to 00 and carries into the day.
- R3: The day wraps to 01 after the last day of the month and carries into the month. The last day is 31 for months 1, 3, 5, 7, 8, 10 and 12, and 30 for months 4, 6, 9 and 11. For month 2 it is 29 when the year is divisible by 4 (including 00) and 28 otherwise. Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00. The weekday advances modulo 7 on every day carry.
- R4: When `hour12`=1, the hours register holds bit 5 = PM and bits 4:0 = hour 01-12 in BCD. The sequence is 12 AM, 01 AM … 11 AM, 12 PM, 01 PM … 11 PM, then 12 AM. Only the step from 11 PM to 12 AM carries into the day.
- R5: While `accActive`=1, no register changes except through a write.
- R6: At most one tick that arrives while `accActive`=1 is remembered. It is applied at the first clock edge with `accActive`=0. Any further ticks in that window are lost.
- R7: A write restarts the prescaler and discards a remembered tick. The next second begins `DIV` enabled cycles after the write edge.
- R8: While `stopHold`=1, the prescaler is held at zero and no tick occurs. The first tick after release comes on the `DIV`th enabled edge after release.
- R9: The oscillator-stop flag (address 0, bit 7) is 1 after reset. `oscStopEvt` sets it, and a write to address 0 loads it from bit 7 of `wrData`.
- R10: One tick occurs per `DIV` clock edges sampled with `oscEn`=1. Edges with `oscEn`=0 do not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| oscEn | input | 1 | Oscillator enable pulse fed to the prescaler |
| stopHold | input | 1 | Holds the prescaler cleared |
| hour12 | input | 1 | 1 = 12-hour format, 0 = 24-hour format |
| accActive | input | 1 | Host access window; freezes the counters |
| regWr | input | 1 | Write strobe |
| regAddr | input | 3 | Register address for read and write |
| wrData | input | 8 | Write data |
| oscStopEvt | input | 1 | Oscillator-stop event pulse |
| rdData | output | 8 | Read data for `regAddr` (combinational) |

## Verification
The bench runs randomly seeded start times, mostly placed a few seconds before a minute boundary, in both hour formats. These runs separate a correct carry chain from one that rolls over at the wrong count. Directed start points cover the year end, February in leap and common years (including year 00), 30-day months, and the 12-hour steps 11 AM→12 PM, 12 PM→1 PM, 12 AM→1 AM and 11 PM→12 AM. These cases separate month-length, leap-year and AM/PM errors. Timing runs hold an access window across three ticks, write during a window that has a remembered tick, hold the stop input, and toggle `oscEn`. These runs separate freezing from losing or duplicating ticks, and expose prescaler restart errors.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
package rtc_cal_pkg;

  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_SEC   = 3'd0;
  localparam logic [ADDR_W-1:0] A_MIN   = 3'd1;
  localparam logic [ADDR_W-1:0] A_HOUR  = 3'd2;
  localparam logic [ADDR_W-1:0] A_DAY   = 3'd3;
  localparam logic [ADDR_W-1:0] A_WDAY  = 3'd4;
  localparam logic [ADDR_W-1:0] A_MONTH = 3'd5;
  localparam logic [ADDR_W-1:0] A_YEAR  = 3'd6;

  typedef struct packed {
    logic              advance;
    logic              wrEn;
    logic [ADDR_W-1:0] wrAddr;
    logic [7:0]        wrData;
  } rtcStrobe_t;

  // two-digit packed BCD increment (caller handles the wrap value)
  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // leap test on a BCD year: binary value divisible by four
  function automatic logic bcdLeap(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    else      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  // last day of a BCD month, returned as BCD
  function automatic logic [5:0] lastDay(input logic [4:0] mon, input logic leap);
    case (mon)
      5'h02:                       return leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11:  return 6'h30;
      default:                     return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
`timescale 1ns/1ps
module rtc_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rstN,
  input  logic oscEn,
  input  logic hold,
  input  logic restart,
  output logic secTick
);
  localparam int DIV_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV - 1);

  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cnt <= '0;
    else if (hold || restart) cnt <= '0;
    else if (oscEn)           cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign secTick = oscEn && !hold && !restart && (cnt == LAST);

  // R8: a held prescaler sits at its start point
  a_r8_hold_clears: assert property (@(posedge clk) disable iff (!rstN)
    hold |=> (cnt == '0));

endmodule

// File: rtl/rtc_ctrl.sv
`timescale 1ns/1ps
module rtc_ctrl
  import rtc_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic              accActive,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        wrData,
  output rtcStrobe_t        strb,
  output logic              pendQ
);
  logic pendNext;

  always_comb begin
    strb.wrEn    = regWr;
    strb.wrAddr  = regAddr;
    strb.wrData  = wrData;
    strb.advance = !accActive && !regWr && (pendQ || secTick);
    if (regWr)          pendNext = 1'b0;
    else if (accActive) pendNext = pendQ || secTick;
    else                pendNext = pendQ && secTick;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= 1'b0;
    else       pendQ <= pendNext;
  end

  // R6: a remembered tick survives until the window closes
  a_r6_pend_kept: assert property (@(posedge clk) disable iff (!rstN)
    (accActive && pendQ && !regWr) |=> pendQ);

endmodule

// File: rtl/rtc_datapath.sv
`timescale 1ns/1ps
module rtc_datapath
  import rtc_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rtcStrobe_t        strb,
  input  logic              hour12,
  input  logic              oscStopEvt,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic [6:0]        secView
);
  logic [6:0] secQ, minQ;
  logic [5:0] hourQ, dayQ;
  logic [2:0] wdayQ;
  logic [4:0] monQ;
  logic [7:0] yearQ;
  logic       osfQ;

  logic       cSec, cMin, cHour, cDay, cMon;
  logic       hourWrap, dayWrap;
  logic [5:0] hourNext;

  always_comb begin
    hourWrap = hour12 ? (hourQ[5] && hourQ[4:0] == 5'h11) : (hourQ == 6'h23);
    if (!hour12)                 hourNext = hourWrap ? 6'h00 : 6'(bcdInc({2'b00, hourQ}));
    else if (hourQ[4:0] == 5'h12) hourNext = {hourQ[5], 5'h01};
    else if (hourQ[4:0] == 5'h11) hourNext = {~hourQ[5], 5'h12};
    else                          hourNext = {hourQ[5], 5'(bcdInc({3'b000, hourQ[4:0]}))};
    dayWrap = (dayQ == lastDay(monQ, bcdLeap(yearQ)));
    cSec  = (secQ == 7'h59);
    cMin  = cSec && (minQ == 7'h59);
    cHour = cMin && hourWrap;
    cDay  = cHour && dayWrap;
    cMon  = cDay && (monQ == 5'h12);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secQ <= '0; minQ <= '0; hourQ <= '0; dayQ <= 6'h01;
      wdayQ <= '0; monQ <= 5'h01; yearQ <= '0; osfQ <= 1'b1;
    end else begin
      if (strb.wrEn) begin
        case (strb.wrAddr)
          A_SEC:   begin secQ <= strb.wrData[6:0]; osfQ <= strb.wrData[7]; end
          A_MIN:   minQ  <= strb.wrData[6:0];
          A_HOUR:  hourQ <= strb.wrData[5:0];
          A_DAY:   dayQ  <= strb.wrData[5:0];
          A_WDAY:  wdayQ <= strb.wrData[2:0];
          A_MONTH: monQ  <= strb.wrData[4:0];
          A_YEAR:  yearQ <= strb.wrData;
          default: ;
        endcase
      end else if (strb.advance) begin
        secQ <= cSec ? 7'h00 : 7'(bcdInc({1'b0, secQ}));
        if (cSec)  minQ  <= (minQ == 7'h59) ? 7'h00 : 7'(bcdInc({1'b0, minQ}));
        if (cMin)  hourQ <= hourNext;
        if (cHour) begin
          dayQ  <= dayWrap ? 6'h01 : 6'(bcdInc({2'b00, dayQ}));
          wdayQ <= (wdayQ == 3'd6) ? 3'd0 : wdayQ + 3'd1;
        end
        if (cDay)  monQ  <= cMon ? 5'h01 : 5'(bcdInc({3'b000, monQ}));
        if (cMon)  yearQ <= (yearQ == 8'h99) ? 8'h00 : bcdInc(yearQ);
      end
      if (oscStopEvt) osfQ <= 1'b1;
    end
  end

  always_comb begin
    case (rdAddr)
      A_SEC:   rdData = {osfQ, secQ};
      A_MIN:   rdData = {1'b0, minQ};
      A_HOUR:  rdData = {2'b00, hourQ};
      A_DAY:   rdData = {2'b00, dayQ};
      A_WDAY:  rdData = {5'b00000, wdayQ};
      A_MONTH: rdData = {3'b000, monQ};
      A_YEAR:  rdData = yearQ;
      default: rdData = 8'h00;
    endcase
  end

  assign secView = secQ;

  // R2: seconds only move on an advance or a write
  a_r2_sec_held: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.advance && !strb.wrEn) |=> $stable(secQ));
  // R1: day and month never read zero, units digit stays decimal
  a_r1_fields_valid: assert property (@(posedge clk) disable iff (!rstN)
    (dayQ != 6'h00) && (monQ != 5'h00) && (secQ[3:0] <= 4'd9));
  // R9: a stop event raises the flag
  a_r9_osf_set: assert property (@(posedge clk) disable iff (!rstN)
    oscStopEvt |=> osfQ);

endmodule

// File: rtl/rtc_calendar_top.sv
`timescale 1ns/1ps
module rtc_calendar_top
  import rtc_cal_pkg::*;
#(
  parameter int DIV = 32768
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       oscEn,
  input  logic       stopHold,
  input  logic       hour12,
  input  logic       accActive,
  input  logic       regWr,
  input  logic [2:0] regAddr,
  input  logic [7:0] wrData,
  input  logic       oscStopEvt,
  output logic [7:0] rdData
);
  logic       secTick;
  logic       pendQ;
  rtcStrobe_t strb;
  logic [6:0] secView;

  rtc_prescaler #(.DIV(DIV)) presc_i (
    .clk(clk), .rstN(rstN), .oscEn(oscEn), .hold(stopHold),
    .restart(regWr), .secTick(secTick)
  );

  rtc_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .secTick(secTick), .accActive(accActive),
    .regWr(regWr), .regAddr(regAddr), .wrData(wrData),
    .strb(strb), .pendQ(pendQ)
  );

  rtc_datapath dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .hour12(hour12),
    .oscStopEvt(oscStopEvt), .rdAddr(regAddr), .rdData(rdData),
    .secView(secView)
  );

  // R5: access window freezes the time
  a_r5_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (accActive && !regWr) |=> $stable(secView));
  // R6: remembered tick is applied once the window closes
  a_r6_served: assert property (@(posedge clk) disable iff (!rstN)
    (!accActive && pendQ && !regWr) |=> (secView != $past(secView)));

endmodule

// File: tb/rtc_calendar_top_tb.sv
`timescale 1ns/1ps
module rtc_calendar_top_tb_top;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic oscEn = 1'b1, stopHold = 1'b0, hour12 = 1'b0, accActive = 1'b0;
  logic regWr = 1'b0, oscStopEvt = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;

  int nChecks = 0, nFails = 0;
  int tS, tM, tH, tD, tW, tMo, tY;
  bit tOsf, m12;

  always #5 clk = ~clk;

  rtc_calendar_top #(.DIV(DIV)) dut_i (
    .clk(clk), .rstN(rstN), .oscEn(oscEn), .stopHold(stopHold),
    .hour12(hour12), .accActive(accActive), .regWr(regWr),
    .regAddr(regAddr), .wrData(wrData), .oscStopEvt(oscStopEvt),
    .rdData(rdData)
  );

  function automatic logic [7:0] toBcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int daysIn(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] hourEnc(int h, bit twelve);
    int h12;
    if (!twelve) return toBcd(h);
    h12 = (h % 12 == 0) ? 12 : h % 12;
    return toBcd(h12) | ((h >= 12) ? 8'h20 : 8'h00);
  endfunction

  function automatic logic [7:0] expReg(int a);
    case (a)
      0: return {tOsf, 7'(toBcd(tS))};
      1: return toBcd(tM);
      2: return hourEnc(tH, m12);
      3: return toBcd(tD);
      4: return 8'(tW);
      5: return toBcd(tMo);
      default: return toBcd(tY);
    endcase
  endfunction

  task automatic advModel(int k);
    for (int i = 0; i < k; i++) begin
      tS++;
      if (tS == 60) begin
        tS = 0; tM++;
        if (tM == 60) begin
          tM = 0; tH++;
          if (tH == 24) begin
            tH = 0; tD++; tW = (tW + 1) % 7;
            if (tD > daysIn(tMo, tY)) begin
              tD = 1; tMo++;
              if (tMo == 13) begin tMo = 1; tY = (tY + 1) % 100; end
            end
          end
        end
      end
    end
  endtask

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp, int a);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s addr %0d: actual %02h expected %02h", req, a, got, exp);
    end
  endtask

  // compares all seven registers without letting a clock edge pass
  task automatic checkAll(string req);
    for (int a = 0; a < 7; a++) begin
      regAddr = 3'(a);
      #0.5;
      chk(req, rdData, expReg(a), a);
    end
  endtask

  task automatic writeReg(int a, logic [7:0] d);
    regWr = 1'b1; regAddr = 3'(a); wrData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic setTime(bit keep);
    accActive = 1'b1;
    tOsf = 1'b0;
    writeReg(0, toBcd(tS));
    writeReg(1, toBcd(tM));
    writeReg(2, hourEnc(tH, m12));
    writeReg(3, toBcd(tD));
    writeReg(4, 8'(tW));
    writeReg(5, toBcd(tMo));
    writeReg(6, toBcd(tY));
    accActive = keep;
  endtask

  task automatic runSec(int k);
    repeat (k * DIV) @(negedge clk);
    advModel(k);
  endtask

  task automatic corner(bit md, int y, int mo, int d, int w, int h, int mi,
                        int s, int k, string req);
    m12 = md; hour12 = md;
    tY = y; tMo = mo; tD = d; tW = w; tH = h; tM = mi; tS = s;
    setTime(1'b0);
    runSec(k);
    checkAll(req);
  endtask

  initial begin
    #2_000_000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_2718));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 and R9: reset contents, flag set
    tS = 0; tM = 0; tH = 0; tD = 1; tW = 0; tMo = 1; tY = 0; tOsf = 1'b1; m12 = 1'b0;
    checkAll("R1");

    // R9: write clears flag, event sets it
    tH = 10; tM = 20; tS = 30; tD = 15; tMo = 6; tY = 42; tW = 3;
    setTime(1'b0);
    checkAll("R9");
    oscStopEvt = 1'b1; @(negedge clk); oscStopEvt = 1'b0;
    tOsf = 1'b1;
    checkAll("R9");

    // R2/R3 directed corners (24-hour)
    corner(0, 99, 12, 31, 6, 23, 59, 59, 1, "R3");
    corner(0, 24,  2, 28, 3, 23, 59, 58, 2, "R3");
    corner(0, 23,  2, 28, 2, 23, 59, 59, 1, "R3");
    corner(0,  0,  2, 29, 1, 23, 59, 59, 1, "R3");
    corner(0, 25,  4, 30, 5, 23, 59, 59, 1, "R3");
    corner(0, 25,  7, 10, 0, 13, 58, 57, 5, "R2");
    // R4: 12-hour steps
    corner(1, 30,  1, 31, 4, 23, 59, 59, 1, "R4");
    corner(1, 30,  3,  5, 4, 11, 59, 59, 1, "R4");
    corner(1, 30,  3,  5, 4, 12, 59, 59, 1, "R4");
    corner(1, 30,  3,  5, 4,  0, 59, 59, 1, "R4");

    // R2: random start points near minute boundaries, both formats
    for (int i = 0; i < 10; i++) begin
      bit md;
      md = 1'($urandom % 2);
      tY = $urandom % 100; tMo = 1 + $urandom % 12;
      corner(md, tY, tMo, 1 + $urandom % daysIn(tMo, tY), $urandom % 7,
             $urandom % 24, 55 + $urandom % 5, 50 + $urandom % 10,
             1 + $urandom % 12, "R2");
    end

    // R5/R6: window held across three ticks, one is applied afterwards
    m12 = 0; hour12 = 0;
    tY = 50; tMo = 8; tD = 8; tW = 2; tH = 8; tM = 8; tS = 8;
    setTime(1'b1);
    repeat (13) @(negedge clk);
    checkAll("R5");
    accActive = 1'b0;
    @(negedge clk);
    advModel(1);
    checkAll("R6");

    // R7: write during a window with a remembered tick discards it
    tS = 20;
    setTime(1'b1);
    repeat (5) @(negedge clk);
    writeReg(1, toBcd(33)); tM = 33;
    accActive = 1'b0;
    checkAll("R7");
    repeat (2) @(negedge clk);
    checkAll("R7");
    repeat (2) @(negedge clk);
    advModel(1);
    checkAll("R7");

    // R8: stop holds time, first tick DIV edges after release
    tS = 40;
    setTime(1'b0);
    stopHold = 1'b1;
    repeat (20) @(negedge clk);
    checkAll("R8");
    stopHold = 1'b0;
    repeat (DIV - 1) @(negedge clk);
    checkAll("R8");
    @(negedge clk);
    advModel(1);
    checkAll("R8");

    // R10: only enabled edges count
    tS = 5;
    setTime(1'b0);
    for (int i = 0; i < 3 * DIV; i++) begin
      oscEn = 1'b0; @(negedge clk);
      oscEn = 1'b1; @(negedge clk);
    end
    advModel(3);
    checkAll("R10");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule